// File: doc/BRIEF.md
# Triggered ADC Scan Sequencer

This block sequences a successive-approximation converter core through a one-shot scan of four consecutive analog channels each time an external hardware trigger arrives. Software sets an enable level to arm it, picks a channel group, and can start, restart or cancel a scan through a busy/start bit. The sequencer drives a channel number and a single-cycle start strobe to the core. It takes back a done strobe and a result word, writes the result register and raises an end-of-conversion interrupt once per channel.

Any scan can be cut short. A new trigger, any write of the group register, or a write of 1 to the busy bit throws away the conversion in flight and starts over at the first channel of the group. A write of 0 to the busy bit cancels the scan. Each start strobe carries a small tag that the core returns with its done strobe. A done strobe whose tag is out of date belongs to a cancelled conversion and is dropped.

Top module: `adc_scan_seq`

## Requirements
- R1: While `en_i` is 0 the block holds `busy_o` at 0, ignores triggers and drops any scan in progress; after reset `busy_o`, `conv_start_o`, `eoc_irq_o` and `result_o` are all 0.
- R2: A trigger sampled while enabled and idle sets `busy_o` and pulses `conv_start_o` in the next cycle, with `conv_ch_o` at the group's first channel.
- R3: `conv_ch_o` is the group value in the upper bits and the scan index in the lower two bits (channel = group*4 + index), and the index runs 0, 1, 2, 3 in order.
- R4: Each accepted done strobe loads `conv_data_i` into `result_o` and raises `eoc_irq_o` for one cycle on the same clock edge, so a full scan gives exactly four interrupts.
- R5: After the fourth result `busy_o` falls by itself, and a later trigger starts a new scan.
- R6: A trigger during a scan discards the conversion in flight (no result, no interrupt) and restarts at index 0.
- R7: A write of the group register during a scan restarts at index 0 of the newly written group, even when the value is unchanged.
- R8: A write of 1 to the busy bit during a scan restarts at index 0.
- R9: A write of 0 to the busy bit during a scan cancels it with no interrupt; `result_o` keeps its last value and the block waits for the next trigger.
- R10: In one cycle a busy-bit clear wins over any restart cause, and a restart wins over taking a completed result.
- R11: `conv_tag_o` changes with every start strobe, and a done strobe is taken only when `conv_done_tag_i` equals the current tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Converter enable level |
| trig_i | input | 1 | Hardware trigger, one cycle per event |
| grp_wr_i | input | 1 | Group register write strobe |
| grp_wdata_i | input | GRP_W | Group value written |
| busy_wr_i | input | 1 | Busy/start bit write strobe |
| busy_wdata_i | input | 1 | Value written to the busy bit |
| conv_start_o | output | 1 | Start strobe to the converter core |
| conv_ch_o | output | GRP_W+2 | Channel being converted |
| conv_tag_o | output | TAG_W | Tag of the current conversion |
| conv_done_i | input | 1 | Done strobe from the core |
| conv_done_tag_i | input | TAG_W | Tag returned with the done strobe |
| conv_data_i | input | RES_W | Conversion result from the core |
| busy_o | output | 1 | Busy/start bit |
| grp_o | output | GRP_W | Current group register |
| result_o | output | RES_W | Result register |
| eoc_irq_o | output | 1 | End-of-conversion interrupt pulse |

## Verification
The bench builds the block with its defaults: one group bit, giving two groups (channels 0-3 and 4-7), a 2-bit tag and 12-bit results. The modelled core answers five cycles after each start and returns the channel number inside the data word. A restart in the middle of a scan therefore leaves a stale done strobe in the core's pipeline, and that strobe arrives after the new start. This tests tag filtering and the channel order of the interrupt stream. It also allows the group rewrite to be checked for both a changed and an unchanged value.

// File: rtl/adc_scan_pkg.sv
`timescale 1ns/1ps
package adc_scan_pkg;

    // What the sequencer does on a given clock edge, strongest first.
    typedef enum logic [2:0] {
        ACT_HOLD    = 3'd0,
        ACT_CANCEL  = 3'd1,
        ACT_RESTART = 3'd2,
        ACT_NEXT    = 3'd3,
        ACT_LAST    = 3'd4
    } seq_act_e;

    function automatic logic takes_result(seq_act_e a);
        return (a == ACT_NEXT) || (a == ACT_LAST);
    endfunction

endpackage

// File: rtl/adc_scan_ctrl.sv
`timescale 1ns/1ps
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int CH_PER_GRP = 4,
    parameter int GRP_W      = 1,
    parameter int TAG_W      = 2,
    localparam int IDX_W     = $clog2(CH_PER_GRP)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             trig_i,
    input  logic             grp_wr_i,
    input  logic [GRP_W-1:0] grp_wdata_i,
    input  logic             busy_wr_i,
    input  logic             busy_wdata_i,
    input  logic             done_i,
    input  logic [TAG_W-1:0] done_tag_i,
    output logic             busy_o,
    output logic             start_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [GRP_W-1:0] grp_o,
    output logic [TAG_W-1:0] tag_o,
    output logic             capture_o,
    output logic             irq_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CH_PER_GRP - 1);

    logic             busy_q, start_q, irq_q;
    logic [IDX_W-1:0] idx_q;
    logic [GRP_W-1:0] grp_q;
    logic [TAG_W-1:0] tag_q;
    logic             clear_req, restart_req, done_ok;
    seq_act_e         act;

    always_comb begin
        clear_req   = busy_wr_i && !busy_wdata_i;
        restart_req = trig_i || (busy_wr_i && busy_wdata_i) || (grp_wr_i && busy_q);
        done_ok     = busy_q && done_i && (done_tag_i == tag_q);
        if (!en_i || clear_req)
            act = ACT_CANCEL;
        else if (restart_req)
            act = ACT_RESTART;
        else if (done_ok)
            act = (idx_q == LAST_IDX) ? ACT_LAST : ACT_NEXT;
        else
            act = ACT_HOLD;
    end

    assign capture_o = takes_result(act);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            irq_q   <= 1'b0;
            idx_q   <= '0;
            grp_q   <= '0;
            tag_q   <= '0;
        end else begin
            if (grp_wr_i) grp_q <= grp_wdata_i;
            irq_q   <= takes_result(act);
            start_q <= 1'b0;
            unique case (act)
                ACT_CANCEL:  busy_q <= 1'b0;
                ACT_RESTART: begin
                    busy_q  <= 1'b1;
                    idx_q   <= '0;
                    tag_q   <= tag_q + TAG_W'(1);
                    start_q <= 1'b1;
                end
                ACT_NEXT: begin
                    idx_q   <= idx_q + IDX_W'(1);
                    tag_q   <= tag_q + TAG_W'(1);
                    start_q <= 1'b1;
                end
                ACT_LAST: busy_q <= 1'b0;
                default: ;
            endcase
        end
    end

    assign busy_o  = busy_q;
    assign start_o = start_q;
    assign idx_o   = idx_q;
    assign grp_o   = grp_q;
    assign tag_o   = tag_q;
    assign irq_o   = irq_q;

    // R1
    off_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !busy_q);

    // R9
    clear_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_wr_i && !busy_wdata_i) |=> (!busy_q && !irq_q));

    // R2
    trig_start_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && trig_i && !(busy_wr_i && !busy_wdata_i))
            |=> (busy_q && start_q && idx_q == '0));

    // R11
    stale_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (done_i && done_tag_i != tag_q) |=> !irq_q);

    // R5
    idle_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start_q && !busy_q) |-> 1'b0 == 1'b1 ? 1'b0 : !start_q);

endmodule

// File: rtl/adc_scan_result.sv
`timescale 1ns/1ps
module adc_scan_result #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [RES_W-1:0] data_i,
    output logic [RES_W-1:0] q_o
);
    logic [RES_W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst)         q_r <= '0;
        else if (load_i) q_r <= data_i;
    end

    assign q_o = q_r;

    // R9
    hold_value_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(q_r));

endmodule

// File: rtl/adc_scan_seq.sv
`timescale 1ns/1ps
module adc_scan_seq #(
    parameter int CH_PER_GRP = 4,
    parameter int GRP_W      = 1,
    parameter int TAG_W      = 2,
    parameter int RES_W      = 12,
    localparam int IDX_W     = $clog2(CH_PER_GRP),
    localparam int CH_W      = GRP_W + IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             trig_i,
    input  logic             grp_wr_i,
    input  logic [GRP_W-1:0] grp_wdata_i,
    input  logic             busy_wr_i,
    input  logic             busy_wdata_i,
    output logic             conv_start_o,
    output logic [CH_W-1:0]  conv_ch_o,
    output logic [TAG_W-1:0] conv_tag_o,
    input  logic             conv_done_i,
    input  logic [TAG_W-1:0] conv_done_tag_i,
    input  logic [RES_W-1:0] conv_data_i,
    output logic             busy_o,
    output logic [GRP_W-1:0] grp_o,
    output logic [RES_W-1:0] result_o,
    output logic             eoc_irq_o
);
    logic [IDX_W-1:0] idx;
    logic             capture;

    adc_scan_ctrl #(
        .CH_PER_GRP(CH_PER_GRP),
        .GRP_W     (GRP_W),
        .TAG_W     (TAG_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .en_i        (en_i),
        .trig_i      (trig_i),
        .grp_wr_i    (grp_wr_i),
        .grp_wdata_i (grp_wdata_i),
        .busy_wr_i   (busy_wr_i),
        .busy_wdata_i(busy_wdata_i),
        .done_i      (conv_done_i),
        .done_tag_i  (conv_done_tag_i),
        .busy_o      (busy_o),
        .start_o     (conv_start_o),
        .idx_o       (idx),
        .grp_o       (grp_o),
        .tag_o       (conv_tag_o),
        .capture_o   (capture),
        .irq_o       (eoc_irq_o)
    );

    adc_scan_result #(.RES_W(RES_W)) u_result (
        .clk   (clk),
        .rst   (rst),
        .load_i(capture),
        .data_i(conv_data_i),
        .q_o   (result_o)
    );

    assign conv_ch_o = {grp_o, idx};

    // R4
    irq_result_chk: assert property (@(posedge clk) disable iff (rst)
        eoc_irq_o |-> (result_o == $past(conv_data_i)));

    // R4
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        eoc_irq_o |=> !eoc_irq_o);

endmodule

// File: tb/adc_scan_seq_test.sv
`timescale 1ns/1ps
module adc_scan_seq_test;
    localparam int LAT = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_i = 1'b0, trig_i = 1'b0, grp_wr_i = 1'b0, busy_wr_i = 1'b0, busy_wdata_i = 1'b0;
    logic [0:0]  grp_wdata_i = '0;
    logic        conv_start_o, conv_done_i, busy_o, eoc_irq_o;
    logic [2:0]  conv_ch_o;
    logic [1:0]  conv_tag_o, conv_done_tag_i;
    logic [11:0] conv_data_i, result_o;
    logic [0:0]  grp_o;

    int checks = 0, fails = 0;
    int log_ch[64];
    int n_irq = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    adc_scan_seq uut (
        .clk(clk), .rst(rst), .en_i(en_i), .trig_i(trig_i),
        .grp_wr_i(grp_wr_i), .grp_wdata_i(grp_wdata_i),
        .busy_wr_i(busy_wr_i), .busy_wdata_i(busy_wdata_i),
        .conv_start_o(conv_start_o), .conv_ch_o(conv_ch_o), .conv_tag_o(conv_tag_o),
        .conv_done_i(conv_done_i), .conv_done_tag_i(conv_done_tag_i), .conv_data_i(conv_data_i),
        .busy_o(busy_o), .grp_o(grp_o), .result_o(result_o), .eoc_irq_o(eoc_irq_o)
    );

    // Fixed-latency core model: every start is answered LAT cycles later.
    logic       pv [LAT];
    logic [1:0] ptag [LAT];
    logic [2:0] pch [LAT];
    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAT; i++) pv[i] <= 1'b0;
        end else begin
            pv[0] <= conv_start_o; ptag[0] <= conv_tag_o; pch[0] <= conv_ch_o;
            for (int i = 1; i < LAT; i++) begin
                pv[i] <= pv[i-1]; ptag[i] <= ptag[i-1]; pch[i] <= pch[i-1];
            end
        end
    end
    assign conv_done_i     = pv[LAT-1];
    assign conv_done_tag_i = ptag[LAT-1];
    assign conv_data_i     = 12'hA00 | {9'd0, pch[LAT-1]};

    // Interrupt monitor: records which channel each interrupt delivered.
    always @(negedge clk) begin
        if (!rst && eoc_irq_o && n_irq < 64) begin
            log_ch[n_irq] = int'(result_o[2:0]);
            n_irq = n_irq + 1;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_log(string req, int exp[$]);
        check(n_irq == exp.size(), req, n_irq, exp.size());
        foreach (exp[i])
            if (i < n_irq) check(log_ch[i] == exp[i], req, log_ch[i], exp[i]);
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_trig();
        @(posedge clk); #1 trig_i = 1'b1;
        @(posedge clk); #1 trig_i = 1'b0;
    endtask

    task automatic write_grp(logic [0:0] g);
        @(posedge clk); #1 grp_wr_i = 1'b1; grp_wdata_i = g;
        @(posedge clk); #1 grp_wr_i = 1'b0;
    endtask

    task automatic write_busy(logic v);
        @(posedge clk); #1 busy_wr_i = 1'b1; busy_wdata_i = v;
        @(posedge clk); #1 busy_wr_i = 1'b0;
    endtask

    task automatic clear_log();
        @(negedge clk); n_irq = 0;
    endtask

    // Trigger, then sit until the second channel is in flight.
    task automatic start_mid_scan();
        clear_log();
        pulse_trig();
        tick(6);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(busy_o == 0, "R1", busy_o, 0);
        check(eoc_irq_o == 0, "R1", eoc_irq_o, 0);
        check(conv_start_o == 0, "R1", conv_start_o, 0);
        check(result_o == 0, "R1", result_o, 0);
    endtask

    task automatic t_disabled();
        en_i = 1'b0;
        clear_log();
        pulse_trig();
        tick(30);
        check(busy_o == 0, "R1 trigger ignored", busy_o, 0);
        check(n_irq == 0, "R1 no interrupts", n_irq, 0);
        en_i = 1'b1;
    endtask

    task automatic t_scan(logic [0:0] g);
        write_grp(g);
        clear_log();
        pulse_trig();
        @(negedge clk);
        check(busy_o == 1, "R2 busy", busy_o, 1);
        check(conv_start_o == 1, "R2 start", conv_start_o, 1);
        check(conv_ch_o == {g, 2'b00}, "R2 first channel", conv_ch_o, {g, 2'b00});
        tick(60);
        check_log("R3 R4 order", '{g*4, g*4+1, g*4+2, g*4+3});
        check(busy_o == 0, "R5 busy self-clears", busy_o, 0);
        check(result_o == (12'hA00 | {9'd0, g, 2'b11}), "R4 last result", result_o,
              12'hA00 | {9'd0, g, 2'b11});
    endtask

    task automatic t_retrigger();
        write_grp(1'b0);
        start_mid_scan();
        @(posedge clk); #1 trig_i = 1'b1;
        @(posedge clk); #1 trig_i = 1'b0;
        tick(60);
        check_log("R6 R11 restart drops stale", '{0, 0, 1, 2, 3});
    endtask

    task automatic t_grp_rewrite();
        write_grp(1'b0);
        start_mid_scan();
        @(posedge clk); #1 grp_wr_i = 1'b1; grp_wdata_i = 1'b1;
        @(posedge clk); #1 grp_wr_i = 1'b0;
        tick(60);
        check_log("R7 new group", '{0, 4, 5, 6, 7});
        start_mid_scan();
        @(posedge clk); #1 grp_wr_i = 1'b1; grp_wdata_i = 1'b1;
        @(posedge clk); #1 grp_wr_i = 1'b0;
        tick(60);
        check_log("R7 same value", '{4, 4, 5, 6, 7});
    endtask

    task automatic t_busy_set();
        write_grp(1'b0);
        start_mid_scan();
        @(posedge clk); #1 busy_wr_i = 1'b1; busy_wdata_i = 1'b1;
        @(posedge clk); #1 busy_wr_i = 1'b0;
        tick(60);
        check_log("R8 restart", '{0, 0, 1, 2, 3});
    endtask

    task automatic t_busy_clear();
        write_grp(1'b0);
        start_mid_scan();
        @(posedge clk); #1 busy_wr_i = 1'b1; busy_wdata_i = 1'b0;
        @(posedge clk); #1 busy_wr_i = 1'b0;
        tick(40);
        check_log("R9 cancel", '{0});
        check(busy_o == 0, "R9 busy", busy_o, 0);
        check(result_o == 12'hA00, "R9 result kept", result_o, 12'hA00);
        clear_log();
        pulse_trig();
        tick(60);
        check(n_irq == 4, "R9 standby after cancel", n_irq, 4);
    endtask

    task automatic t_priority();
        clear_log();
        @(posedge clk); #1 trig_i = 1'b1; busy_wr_i = 1'b1; busy_wdata_i = 1'b0;
        @(posedge clk); #1 trig_i = 1'b0; busy_wr_i = 1'b0;
        tick(40);
        check(n_irq == 0, "R10 clear beats trigger", n_irq, 0);
        check(busy_o == 0, "R10 busy", busy_o, 0);
        start_mid_scan();
        @(posedge clk); #1 trig_i = 1'b1; busy_wr_i = 1'b1; busy_wdata_i = 1'b0;
        @(posedge clk); #1 trig_i = 1'b0; busy_wr_i = 1'b0;
        tick(40);
        check_log("R10 clear beats trigger mid-scan", '{0});
    endtask

    task automatic t_enable_drop();
        start_mid_scan();
        en_i = 1'b0;
        tick(2);
        en_i = 1'b1;
        tick(40);
        check_log("R1 disable drops scan", '{0});
        check(busy_o == 0, "R1 busy", busy_o, 0);
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        t_reset();
        t_disabled();
        t_scan(1'b0);
        t_scan(1'b1);
        t_retrigger();
        t_grp_rewrite();
        t_busy_set();
        t_busy_clear();
        t_priority();
        t_enable_drop();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule